// File: doc/BRIEF.md
# Dual-Channel DAC Serial Write Controller

This block is the host side of a link to a two-channel, double-buffered DAC that takes its words over a three-wire serial port and has a separate active-low load strobe. A command port with a valid/ready handshake accepts one operation at a time. A write command carries a channel code, a data word and an update-mode bit. An update command carries no data and only pulses the load strobe. Each write goes out as one 24-bit frame with chip select held low. The frame is right-justified, with zero padding above a 2-bit channel code, and the data word follows the code most significant bit first.

To change both outputs at the same moment, the host sends a deferred write to channel A, then a deferred write to channel B, then one update command. The strobe then falls once. An immediate write pulses the strobe by itself right after its frame. The both-channels code loads a single value into both channels with one frame.

Timing comes from parameters counted in system clocks. `DIV` sets each serial clock half-period and the clock-low hold before chip select rises. `GAP` sets the idle time after chip select rises and after every strobe pulse. `LDW` sets the width of the strobe pulse. `DATA_W` (16 or 14) sets how many zero pad bits lead the frame.

Top module: `dacser_ctrl`

## Requirements
- R1: During and directly after reset, csn_o and ldn_o are high, sclk_o is low and cmd_ready_o is high. A reset in the middle of a frame returns all four to these values at once.
- R2: A write command produces exactly one chip-select low period with exactly 24 sclk_o rising edges. sdi_o is sampled on those edges and carries frame bit 23 first and bit 0 last.
- R3: The frame holds the data word in bits [DATA_W-1:0] and the channel code in bits [DATA_W+1:DATA_W], with zeros above. The channel codes are 2'b01 for channel A, 2'b10 for channel B, 2'b11 for both and 2'b00 for none, and each is sent as given.
- R4: sclk_o is low whenever csn_o is high. sclk_o is also low in the cycle before and the cycle of every csn_o rising edge.
- R5: While csn_o is low, every sclk_o high phase and every sclk_o low phase lasts at least DIV system clocks. sdi_o never changes while sclk_o is high.
- R6: A write with the mode bit cmd_imm_i = 0 leaves ldn_o high for the whole operation.
- R7: A write with cmd_imm_i = 1 gives exactly one ldn_o low pulse of LDW cycles. The pulse starts at least GAP cycles after csn_o rises, and ldn_o is never low while csn_o is low.
- R8: An update command (cmd_upd_i = 1) sends no frame, so csn_o stays high. It gives exactly one ldn_o low pulse, whatever the channel, data and mode inputs are.
- R9: cmd_ready_o falls in the cycle after a command is accepted. It stays low until the frame, any strobe pulse and the trailing idle gap have all finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Controller idle, command taken when valid is high |
| cmd_upd_i | input | 1 | 1: strobe-only update command, no frame |
| cmd_imm_i | input | 1 | 1: pulse the strobe right after the frame |
| cmd_chan_i | input | 2 | Channel code placed in the frame |
| cmd_data_i | input | DATA_W | Data word |
| sclk_o | output | 1 | Serial clock to the DAC |
| sdi_o | output | 1 | Serial data to the DAC |
| csn_o | output | 1 | Chip select, active low |
| ldn_o | output | 1 | Load strobe, active low |

## Verification
The bench reads every frame back from the pins and looks for four kinds of error. The first is a frame shifted by one bit or with the channel code in the wrong place, which shows up as a wrong captured word or a count other than 24 edges. The second is a serial clock that runs while chip select is high, or that is still high when chip select rises, which would corrupt the word the DAC latches. The third is half-periods shorter than `DIV`, or data that changes while the clock is high. The last group covers strobe faults: a pulse after a deferred write, which would break the simultaneous update; a missing or narrow pulse after an immediate write; a frame sent by an update command; and a reset in the middle of a frame that leaves chip select or the strobe asserted.

// File: rtl/dacser_pkg.sv
package dacser_pkg;
  localparam int unsigned FRAME_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_TAIL,
    ST_GAP1,
    ST_STB,
    ST_GAP2
  } seq_st_e;
endpackage

// File: rtl/dacser_frame.sv
module dacser_frame
  import dacser_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [1:0]         chan_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int PAD = int'(FRAME_W) - int'(DATA_W) - 2;

  generate
    if (PAD > 0) begin : g_pad
      assign frame_o = {{PAD{1'b0}}, chan_i, data_i};
    end else begin : g_nopad
      assign frame_o = {chan_i, data_i};
    end
  endgenerate
endmodule

// File: rtl/dacser_shreg.sv
module dacser_shreg #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               sdi_o,
  output logic               last_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sreg_q <= frame_i;
      left_q <= CNT_W'(FRAME_W - 1);
    end else if (shift_i) begin
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign sdi_o  = sreg_q[FRAME_W-1];
  assign last_o = (left_q == '0);

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i)); // R2
endmodule

// File: rtl/dacser_timer.sv
module dacser_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dacser_ctrl.sv
module dacser_ctrl
  import dacser_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DIV    = 2,
  parameter int unsigned GAP    = 2,
  parameter int unsigned LDW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_upd_i,
  input  logic              cmd_imm_i,
  input  logic [1:0]        cmd_chan_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              csn_o,
  output logic              ldn_o
);
  localparam int unsigned TMAX = (DIV > GAP) ? ((DIV > LDW) ? DIV : LDW)
                                             : ((GAP > LDW) ? GAP : LDW);
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] DIV_M1 = CW'(DIV - 1);
  localparam logic [CW-1:0] GAP_M1 = CW'(GAP - 1);
  localparam logic [CW-1:0] LDW_M1 = CW'(LDW - 1);

  initial begin : p_param_chk
    AST_DATA_FITS: assert (DATA_W + 2 <= FRAME_W && DIV >= 1 && GAP >= 1 && LDW >= 1)
      else $error("dacser_ctrl: bad parameters"); // R3
  end

  seq_st_e             st_q, st_d;
  logic                imm_q;
  logic                accept;
  logic                tmr_load, tmr_done;
  logic [CW-1:0]       tmr_val;
  logic                sh_load, sh_shift, sh_last;
  logic [FRAME_W-1:0]  frame;

  assign accept = cmd_valid_i && cmd_ready_o;

  dacser_frame #(.DATA_W(DATA_W)) u_frame (
    .chan_i  (cmd_chan_i),
    .data_i  (cmd_data_i),
    .frame_o (frame)
  );

  dacser_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .frame_i (frame),
    .shift_i (sh_shift),
    .sdi_o   (sdi_o),
    .last_o  (sh_last)
  );

  dacser_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (cmd_upd_i) begin
          st_d    = ST_STB;
          tmr_val = LDW_M1;
        end else begin
          st_d    = ST_LO;
          tmr_val = DIV_M1;
          sh_load = 1'b1;
        end
      end
      ST_LO: if (tmr_done) begin
        st_d     = ST_HI;
        tmr_load = 1'b1;
        tmr_val  = DIV_M1;
      end
      ST_HI: if (tmr_done) begin
        sh_shift = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = DIV_M1;
        st_d     = sh_last ? ST_TAIL : ST_LO;
      end
      ST_TAIL: if (tmr_done) begin
        st_d     = ST_GAP1;
        tmr_load = 1'b1;
        tmr_val  = GAP_M1;
      end
      ST_GAP1: if (tmr_done) begin
        if (imm_q) begin
          st_d     = ST_STB;
          tmr_load = 1'b1;
          tmr_val  = LDW_M1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_STB: if (tmr_done) begin
        st_d     = ST_GAP2;
        tmr_load = 1'b1;
        tmr_val  = GAP_M1;
      end
      ST_GAP2: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      imm_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept && !cmd_upd_i) imm_q <= cmd_imm_i;
    end
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign csn_o       = !(st_q inside {ST_LO, ST_HI, ST_TAIL});
  assign sclk_o      = (st_q == ST_HI);
  assign ldn_o       = (st_q != ST_STB);

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o); // R9
  AST_CS_RISE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csn_o) |-> (!sclk_o && !$past(sclk_o))); // R4
  AST_SDI_STABLE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdi_o)); // R5
  AST_STB_OUTSIDE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldn_o |-> csn_o); // R7
endmodule

// File: tb/dacser_ctrl_test.sv
`timescale 1ns/1ps
module dacser_ctrl_test;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned DIV    = 2;
  localparam int unsigned GAP    = 2;
  localparam int unsigned LDW    = 3;

  // vector: [19] upd, [18] imm, [17:16] chan, [15:0] data
  localparam logic [19:0] VEC [0:7] = '{
    20'h11234, // A deferred
    20'h2ABCD, // B deferred
    20'h80000, // update strobe
    20'h7FFFF, // both, immediate
    20'h50001, // A immediate
    20'h28000, // B deferred
    20'h05555, // none code, deferred
    20'hF0000  // update with other fields set
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_upd = 1'b0, cmd_imm = 1'b0;
  logic [1:0] cmd_chan = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic cmd_ready, sclk, sdi, csn, ldn;

  always #2.5 clk = ~clk;

  dacser_ctrl #(.DATA_W(DATA_W), .DIV(DIV), .GAP(GAP), .LDW(LDW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_upd_i(cmd_upd), .cmd_imm_i(cmd_imm), .cmd_chan_i(cmd_chan), .cmd_data_i(cmd_data),
    .sclk_o(sclk), .sdi_o(sdi), .csn_o(csn), .ldn_o(ldn)
  );

  int n_cmp = 0, n_mis = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // pin monitor, sampled on the falling edge
  int cyc = 0, cs_falls = 0, nbits = 0, ld_falls = 0, viol = 0;
  int ph = 0, ldw_cnt = 0, last_ldw = 0, gap = 0, cs_rise_cyc = 0;
  logic [23:0] cap = '0;
  logic p_csn = 1'b1, p_sclk = 1'b0, p_ldn = 1'b1, p_sdi = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (csn && sclk) viol++;
    if (csn && !p_csn && p_sclk) viol++;
    if (!csn && p_csn) begin
      cs_falls++;
      ph = 1;
    end else if (!csn) begin
      if (sclk == p_sclk) ph++;
      else begin
        if (ph < int'(DIV)) viol++;
        ph = 1;
      end
    end
    if (sclk && !p_sclk && !csn) begin
      cap = {cap[22:0], sdi};
      nbits++;
    end
    if (sclk && p_sclk && (sdi != p_sdi)) viol++;
    if (!ldn && !csn) viol++;
    if (csn && !p_csn) cs_rise_cyc = cyc;
    if (!ldn && p_ldn) begin
      ld_falls++;
      ldw_cnt = 1;
      gap = cyc - cs_rise_cyc;
    end else if (!ldn) ldw_cnt++;
    if (ldn && !p_ldn) last_ldw = ldw_cnt;
    p_csn = csn; p_sclk = sclk; p_ldn = ldn; p_sdi = sdi;
  end

  task automatic run_cmd(input logic [19:0] v);
    int b_falls, b_bits, b_ld, b_viol, tmo;
    logic [23:0] exp;
    @(negedge clk); #1;
    b_falls = cs_falls; b_bits = nbits; b_ld = ld_falls; b_viol = viol;
    cmd_valid = 1'b1; cmd_upd = v[19]; cmd_imm = v[18];
    cmd_chan = v[17:16]; cmd_data = v[15:0];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!cmd_ready, "R9 ready after accept", longint'(cmd_ready), 0);
    tmo = 0;
    while (!cmd_ready && tmo < 5000) begin
      @(negedge clk);
      tmo++;
    end
    check(tmo < 5000, "R9 ready returns", tmo, 0);
    @(negedge clk); #1;
    exp = (24'(v[17:16]) << DATA_W) | 24'(v[15:0]);
    if (v[19]) begin
      check(cs_falls - b_falls == 0, "R8 no frame", cs_falls - b_falls, 0);
      check(ld_falls - b_ld == 1, "R8 one strobe", ld_falls - b_ld, 1);
    end else begin
      check(cs_falls - b_falls == 1, "R2 one frame", cs_falls - b_falls, 1);
      check(nbits - b_bits == 24, "R2 edge count", nbits - b_bits, 24);
      check(cap == exp, "R3 frame word", cap, exp);
      if (v[18]) begin
        check(ld_falls - b_ld == 1, "R7 one strobe", ld_falls - b_ld, 1);
        check(last_ldw == int'(LDW), "R7 strobe width", last_ldw, LDW);
        check(gap >= int'(GAP), "R7 gap after cs", gap, GAP);
      end else begin
        check(ld_falls - b_ld == 0, "R6 no strobe", ld_falls - b_ld, 0);
      end
    end
    check(viol - b_viol == 0, "R4_R5 timing", viol - b_viol, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog act=expired exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin : main
    int vb;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(csn == 1'b1, "R1 csn", csn, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    check(ldn == 1'b1, "R1 ldn", ldn, 1);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(csn && !sclk && ldn && cmd_ready, "R1 after release",
          {csn, sclk, ldn, cmd_ready}, 4'b1011);

    for (int i = 0; i < 8; i++) run_cmd(VEC[i]);

    // simultaneous update: A then B deferred, then one strobe
    run_cmd(20'h10F0F);
    run_cmd(20'h20F0F);
    run_cmd(20'h80000);

    // R1: reset in the middle of a frame
    @(negedge clk);
    cmd_valid = 1'b1; cmd_upd = 1'b0; cmd_imm = 1'b1;
    cmd_chan = 2'b11; cmd_data = 16'hC3C3;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(!csn, "R2 frame in progress", csn, 0);
    rst_ni = 1'b0;
    #1;
    check(csn && !sclk && ldn && cmd_ready, "R1 mid-frame reset",
          {csn, sclk, ldn, cmd_ready}, 4'b1011);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    vb = viol;
    run_cmd(20'h6A5A5);
    check(viol == vb, "R4 recovery clean", viol - vb, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule